// File: doc/BRIEF.md
# Host Byte-Bus to Serial Link Adapter

This block joins an 8-bit host bus to a single bit-serial link of a processor network. To the network it behaves like one more link partner. To the host it is a small window of four byte-wide registers, picked by a 2-bit select: a receive data byte, a transmit data byte, a receive status and a transmit status. Each direction holds exactly one byte, and a one-bit flag marks that byte as present or absent.

A byte the host writes is sent on the link as one data frame. The transmit side stays busy until the link partner returns an acknowledge frame. A data frame that arrives from the link is stored in the receive byte. The adapter returns its own acknowledge only after the host has read that byte out, and this stops the partner from overrunning the single receive slot. Both directions run at the same time. One shifter carries the outgoing data frames and acknowledge frames, and an acknowledge that is waiting is sent before a data byte that is waiting.

Top module: `hla_top`

## Requirements
- R1: After reset the receive status (select 2) reads 0, the transmit status (select 3) reads 1, and the outgoing link line is low.
- R2: Register select 0 reads the receive byte. Select 1 is the transmit byte (write). Select 2 bit 0 is 1 when a received byte is waiting. Select 3 bit 0 is 1 when the transmit byte is free. Status bits 7..1 read 0.
- R3: A host write to select 1 while the transmit byte is free puts a data frame on the link, one bit per clock: 1, 1, the eight data bits least significant first, then 0. Transmit status reads 0 from the cycle after the write.
- R4: Transmit status stays 0 until an acknowledge frame (bit 1 then bit 0) arrives from the partner after the data frame was sent. It then returns to 1.
- R5: A write to select 1 while transmit status is 0 is dropped and no further data frame is sent for it.
- R6: A well-formed incoming data frame sets receive status to 1, and select 0 returns its byte.
- R7: While a received byte is unread, no acknowledge frame is sent. A host read of select 0 clears receive status, and an acknowledge frame (1, 0) follows on the link.
- R8: An incoming data frame whose final bit is not 0 is discarded: receive status stays 0 and no acknowledge is sent.
- R9: Writes to selects 0, 2 and 3 change neither status nor the link.
- R10: An acknowledge frame that arrives while no data byte is outstanding is ignored. It does not free the next byte in advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one link bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; reading select 0 consumes the byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current select |
| link_rx | input | 1 | Serial line from the partner, idle low |
| link_tx | output | 1 | Serial line to the partner, idle low |

## Verification
If a buffer flag is wrong, a status register shows it on the next read. If the flag is stuck full, the matching frame or acknowledge never appears on the link. If the flag clears too early, an extra frame or acknowledge appears within about a dozen cycles. A deserializer that is out of step returns a byte that differs from the one sent, and a frame it should reject sets the receive status within a few cycles. The bench sweeps every byte value in both directions. It also holds the link idle for long windows, so that a missing hold-off shows up as traffic the partner did not ask for.

// File: rtl/hla_pkg.sv
package hla_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] SEL_RXDATA = 2'd0;
  localparam logic [1:0] SEL_TXDATA = 2'd1;
  localparam logic [1:0] SEL_RXSTAT = 2'd2;
  localparam logic [1:0] SEL_TXSTAT = 2'd3;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_KIND = 2'd1,
    RX_BITS = 2'd2,
    RX_TAIL = 2'd3
  } rx_state_e;
endpackage

// File: rtl/hla_tx.sv
module hla_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_ack,
  input  logic          want_data,
  input  logic [DW-1:0] data_i,
  output logic          take_ack,
  output logic          take_data,
  output logic          line_o
);
  localparam int unsigned FLEN = DW + 3;
  localparam int unsigned CW   = $clog2(FLEN + 1);

  logic [FLEN-1:0] sh_q, sh_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            busy_q, busy_d;

  always_comb begin
    take_ack  = !busy_q && want_ack;
    take_data = !busy_q && !want_ack && want_data;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (take_ack) begin
      sh_d   = FLEN'(2'b01);
      cnt_d  = CW'(2);
      busy_d = 1'b1;
    end else if (take_data) begin
      sh_d   = {1'b0, data_i, 2'b11};
      cnt_d  = CW'(FLEN);
      busy_d = 1'b1;
    end else if (busy_q) begin
      sh_d   = sh_q >> 1;
      cnt_d  = cnt_q - CW'(1);
      busy_d = (cnt_q != CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign line_o = busy_q & sh_q[0];

  a_r3_frame_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> line_o);
endmodule

// File: rtl/hla_rx.sv
module hla_rx #(
  parameter int unsigned DW   = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  output logic          byte_vld,
  output logic          ack_seen,
  output logic [DW-1:0] byte_o
);
  import hla_pkg::*;
  localparam int unsigned CW = $clog2(DW);

  logic            s;
  rx_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic            vld_q, vld_d, ack_q, ack_d;

  generate
    if (SYNC == 0) begin : g_nosync
      assign s = line_i;
    end else if (SYNC == 1) begin : g_sync1
      logic sy_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sy_q <= 1'b0; else sy_q <= line_i;
      assign s = sy_q;
    end else begin : g_syncn
      logic [SYNC-1:0] sy_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sy_q <= '0; else sy_q <= {sy_q[SYNC-2:0], line_i};
      assign s = sy_q[SYNC-1];
    end
  endgenerate

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    ack_d = 1'b0;
    unique case (st_q)
      RX_IDLE: if (s) st_d = RX_KIND;
      RX_KIND: begin
        cnt_d = '0;
        if (s) st_d = RX_BITS;
        else begin
          ack_d = 1'b1;
          st_d  = RX_IDLE;
        end
      end
      RX_BITS: begin
        sh_d  = {s, sh_q[DW-1:1]};
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(DW - 1)) st_d = RX_TAIL;
      end
      RX_TAIL: begin
        vld_d = !s;
        st_d  = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
      ack_q <= ack_d;
    end
  end

  assign byte_vld = vld_q;
  assign ack_seen = ack_q;
  assign byte_o   = sh_q;

  a_r8_one_event_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && ack_q));
endmodule

// File: rtl/hla_top.sv
module hla_top #(
  parameter int unsigned DW   = hla_pkg::BYTE_W,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          link_rx,
  output logic          link_tx
);
  import hla_pkg::*;

  logic          rx_vld, rx_ack;
  logic [DW-1:0] rx_byte;
  logic          take_ack, take_data;

  logic          in_full_q, in_full_d;
  logic [DW-1:0] in_data_q, in_data_d;
  logic          ack_pend_q, ack_pend_d;
  logic          out_full_q, out_full_d;
  logic          out_sent_q, out_sent_d;
  logic [DW-1:0] out_data_q, out_data_d;

  logic host_take, host_put;

  hla_rx #(.DW(DW), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_i(link_rx),
    .byte_vld(rx_vld), .ack_seen(rx_ack), .byte_o(rx_byte)
  );

  hla_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .want_ack(ack_pend_q && !in_full_q),
    .want_data(out_full_q && !out_sent_q),
    .data_i(out_data_q),
    .take_ack(take_ack), .take_data(take_data), .line_o(link_tx)
  );

  assign host_take = bus_rd && (bus_sel == SEL_RXDATA);
  assign host_put  = bus_wr && (bus_sel == SEL_TXDATA) && !out_full_q;

  always_comb begin
    in_full_d  = in_full_q;
    in_data_d  = in_data_q;
    ack_pend_d = ack_pend_q;
    if (take_ack) ack_pend_d = 1'b0;
    if (host_take) in_full_d = 1'b0;
    if (rx_vld && !in_full_q) begin
      in_full_d  = 1'b1;
      in_data_d  = rx_byte;
      ack_pend_d = 1'b1;
    end
  end

  always_comb begin
    out_full_d = out_full_q;
    out_sent_d = out_sent_q;
    out_data_d = out_data_q;
    if (take_data) out_sent_d = 1'b1;
    if (rx_ack && out_sent_q) begin
      out_full_d = 1'b0;
      out_sent_d = 1'b0;
    end
    if (host_put) begin
      out_full_d = 1'b1;
      out_data_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full_q  <= 1'b0;
      in_data_q  <= '0;
      ack_pend_q <= 1'b0;
      out_full_q <= 1'b0;
      out_sent_q <= 1'b0;
      out_data_q <= '0;
    end else begin
      in_full_q  <= in_full_d;
      in_data_q  <= in_data_d;
      ack_pend_q <= ack_pend_d;
      out_full_q <= out_full_d;
      out_sent_q <= out_sent_d;
      out_data_q <= out_data_d;
    end
  end

  always_comb begin
    unique case (bus_sel)
      SEL_RXDATA: bus_rdata = in_data_q;
      SEL_RXSTAT: bus_rdata = {{(DW-1){1'b0}}, in_full_q};
      SEL_TXSTAT: bus_rdata = {{(DW-1){1'b0}}, !out_full_q};
      default:    bus_rdata = '0;
    endcase
  end

  a_r4_free_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_full_q) |-> $past(rx_ack));
  a_r6_full_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_full_q) |-> $past(rx_vld));
  a_r7_ack_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    take_ack |-> !in_full_q);
  a_r3_no_data_while_sent: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |-> out_full_q && !out_sent_q);
endmodule

// File: tb/hla_top_test.sv
module hla_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       link_rx = 1'b0;
  logic       link_tx;

  int n_chk = 0, n_err = 0;
  int data_cnt = 0, ack_cnt = 0, bad_cnt = 0;
  logic [7:0] last_byte = 8'd0;

  hla_top uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // partner side: decode outgoing link at falling edges
  int mst = 0, mbit = 0;
  logic [7:0] msh = 8'd0;
  always @(negedge clk) begin
    if (rst_n) begin
      case (mst)
        0: if (link_tx) mst = 1;
        1: if (link_tx) begin mst = 2; mbit = 0; end
           else begin ack_cnt++; mst = 0; end
        2: begin
             msh = {link_tx, msh[7:1]};
             mbit++;
             if (mbit == 8) mst = 3;
           end
        default: begin
             if (link_tx) bad_cnt++;
             else begin data_cnt++; last_byte = msh; end
             mst = 0;
           end
      endcase
    end
  end

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    bus_sel = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic tail);
    logic [10:0] f;
    f = {tail, d, 2'b11};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); link_rx = f[i];
    end
    @(negedge clk); link_rx = 1'b0;
  endtask

  task automatic send_ack();
    @(negedge clk); link_rx = 1'b1;
    @(negedge clk); link_rx = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_cnt(ref int c, input int prev, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim && !ok; i++) begin
      @(negedge clk); #2;
      if (c > prev) ok = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit ok;
    int d0, a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R2 reset state
    bus_read(2'd2, v); chk(v == 8'h00, "R1 rx status", v, 0);
    bus_read(2'd3, v); chk(v == 8'h01, "R1 tx status", v, 1);
    chk(link_tx == 1'b0, "R1 link idle", link_tx, 0);

    // R9 writes to read-only selects
    d0 = data_cnt; a0 = ack_cnt;
    bus_write(2'd0, 8'hFF); bus_write(2'd2, 8'hFF); bus_write(2'd3, 8'hFF);
    idle(30);
    chk(data_cnt == d0 && ack_cnt == a0, "R9 link quiet", data_cnt - d0 + ack_cnt - a0, 0);
    bus_read(2'd2, v); chk(v == 8'h00, "R9 rx status", v, 0);
    bus_read(2'd3, v); chk(v == 8'h01, "R9 tx status", v, 1);

    // R10 stray acknowledge
    send_ack(); idle(5);
    d0 = data_cnt;
    bus_write(2'd1, 8'h5A);
    wait_cnt(data_cnt, d0, 40, ok);
    chk(ok && last_byte == 8'h5A, "R10 frame after stray ack", last_byte, 8'h5A);
    idle(20);
    bus_read(2'd3, v); chk(v == 8'h00, "R10 still busy", v, 0);

    // R4/R5: held busy, extra write dropped
    bus_write(2'd1, 8'hC3);
    idle(30);
    chk(data_cnt == d0 + 1, "R5 no extra frame", data_cnt - d0, 1);
    bus_read(2'd3, v); chk(v == 8'h00, "R4 busy without ack", v, 0);
    send_ack(); idle(6);
    bus_read(2'd3, v); chk(v == 8'h01, "R4 free after ack", v, 1);
    idle(30);
    chk(data_cnt == d0 + 1, "R5 dropped byte never sent", data_cnt - d0, 1);

    // R3/R4 sweep of all transmit bytes
    for (int b = 0; b < 256; b++) begin
      d0 = data_cnt;
      bus_write(2'd1, 8'(b));
      bus_read(2'd3, v); chk(v == 8'h00, "R3 status busy", v, 0);
      wait_cnt(data_cnt, d0, 40, ok);
      chk(ok && last_byte == 8'(b), "R3 frame byte", last_byte, b);
      send_ack(); idle(6);
      bus_read(2'd3, v); chk(v == 8'h01, "R4 released", v, 1);
    end
    chk(bad_cnt == 0, "R3 closing bit low", bad_cnt, 0);

    // R8 malformed frame
    a0 = ack_cnt;
    send_frame(8'hA5, 1'b1); idle(30);
    bus_read(2'd2, v); chk(v == 8'h00, "R8 rejected frame", v, 0);
    chk(ack_cnt == a0, "R8 no ack", ack_cnt - a0, 0);

    // R6/R7 receive sweep
    for (int b = 0; b < 256; b++) begin
      a0 = ack_cnt;
      send_frame(8'(b), 1'b0); idle(6);
      bus_read(2'd2, v); chk(v == 8'h01, "R6 rx status", v, 1);
      if (b % 32 == 0) begin
        idle(30);
        chk(ack_cnt == a0, "R7 ack withheld", ack_cnt - a0, 0);
      end
      bus_read(2'd0, v); chk(v == 8'(b), "R6 rx byte", v, b);
      bus_read(2'd2, v); chk(v == 8'h00, "R7 status cleared", v, 0);
      wait_cnt(ack_cnt, a0, 20, ok);
      chk(ok, "R7 ack after read", ack_cnt - a0, 1);
    end

    idle(10);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule